// File: doc/BRIEF.md
# Iterative SHA-256 Compression Core

This block applies the SHA-256 compression function to one 512-bit message block at a time and spends one clock per round. The caller presents the sixteen 32-bit words of an already padded block on a single flat bus and raises a level start signal. The core copies the block and the current chaining value into its own registers and runs the 64 rounds. It then adds the final working variables into the chaining value and raises a ready flag. Padding, length encoding and splitting a message into blocks are done outside the core.

A synchronous reset loads the standard initial hash value and so begins a new message. Each block that completes without a reset in between chains from the digest of the block before it, which is how messages longer than one block are hashed. The eight working variables are also exposed as separate outputs.

The controller has three states. ST_IDLE waits. Start sampled high in ST_IDLE moves it to ST_RUN and loads the block. ST_RUN counts the rounds 0 to 63, and the edge that computes round 63 moves it to ST_DONE. ST_DONE holds while start stays high and returns to ST_IDLE on the first edge that samples start low. Reset forces ST_IDLE from any state.

Top module: `sha256_iter_core`

## Requirements
- R1: After a reset edge, ready_o is 0 and digest_o holds the initial hash value 6a09e667 bb67ae85 3c6ef372 a54ff53a 510e527f 9b05688c 1f83d9ab 5be0cd19, with H0 in bits 255:224 down to H7 in bits 31:0. a_o to h_o hold the same eight words in that order.
- R2: Word i of blk_i sits in bits 32*i+31:32*i. Word 15 is schedule word W0, the first word of the block, and word 0 is W15.
- R3: The rising clock edge that samples start_i high in ST_IDLE latches blk_i. ready_o is 0 after the next 63 edges and becomes 1 after the 64th of them, so a digest is due 65 edges after start is first sampled.
- R4: When ready_o rises, digest_o equals the SHA-256 compression of the latched block with the chaining value that was current when the block was latched. The one-block message "abc" gives ba7816bf...f20015ad. The two-block 56-byte message gives 85e655d6...f20e533a after its first block and 248d6a61...19db06c1 after its second.
- R5: While start_i stays high in ST_DONE, ready_o stays 1 and digest_o does not change. No second compression begins.
- R6: The first edge that samples start_i low in ST_DONE clears ready_o and keeps digest_o. A later start then compresses the new block using that digest as its chaining value.
- R7: A reset during a compression abandons it. The core returns to ST_IDLE with the initial hash value as its chaining value.
- R8: When ready_o rises, a_o to h_o hold the working variables after round 63, before they are added to the chaining value.
- R9: Changes on start_i and blk_i during ST_RUN do not affect the running compression or its result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high; begins a new message |
| start_i | input | 1 | Level request to compress the block on blk_i |
| blk_i | input | 512 | Sixteen message words; word 15 is W0 |
| a_o | output | 32 | Working variable a |
| b_o | output | 32 | Working variable b |
| c_o | output | 32 | Working variable c |
| d_o | output | 32 | Working variable d |
| e_o | output | 32 | Working variable e |
| f_o | output | 32 | Working variable f |
| g_o | output | 32 | Working variable g |
| h_o | output | 32 | Working variable h |
| ready_o | output | 1 | High in ST_DONE: digest_o is valid |
| digest_o | output | 256 | Chaining value, H0 in bits 255:224 |

## Verification
Every block is launched at a falling edge. The bench counts rising edges from the one that samples start: it checks ready_o low after the 64th edge and high after the 65th, and it compares the digest and working variables at that same falling edge. The release of start is checked one edge later, when ready_o has to fall and the digest has to stay. A reset is checked one edge after it is applied. Expected values come from a bench model of the compression function that tracks the chaining value across blocks and resets. Its results are checked against the published vectors and against seeded random blocks.

// File: rtl/sha256_pkg.sv
package sha256_pkg;

    localparam int WORD_W = 32;

    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        word_t a;
        word_t b;
        word_t c;
        word_t d;
        word_t e;
        word_t f;
        word_t g;
        word_t h;
    } vars_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_DONE
    } phase_t;

    localparam vars_t IV = '{
        a: 32'h6a09e667, b: 32'hbb67ae85, c: 32'h3c6ef372, d: 32'ha54ff53a,
        e: 32'h510e527f, f: 32'h9b05688c, g: 32'h1f83d9ab, h: 32'h5be0cd19
    };

    localparam word_t K_TAB [64] = '{
        32'h428a2f98, 32'h71374491, 32'hb5c0fbcf, 32'he9b5dba5,
        32'h3956c25b, 32'h59f111f1, 32'h923f82a4, 32'hab1c5ed5,
        32'hd807aa98, 32'h12835b01, 32'h243185be, 32'h550c7dc3,
        32'h72be5d74, 32'h80deb1fe, 32'h9bdc06a7, 32'hc19bf174,
        32'he49b69c1, 32'hefbe4786, 32'h0fc19dc6, 32'h240ca1cc,
        32'h2de92c6f, 32'h4a7484aa, 32'h5cb0a9dc, 32'h76f988da,
        32'h983e5152, 32'ha831c66d, 32'hb00327c8, 32'hbf597fc7,
        32'hc6e00bf3, 32'hd5a79147, 32'h06ca6351, 32'h14292967,
        32'h27b70a85, 32'h2e1b2138, 32'h4d2c6dfc, 32'h53380d13,
        32'h650a7354, 32'h766a0abb, 32'h81c2c92e, 32'h92722c85,
        32'ha2bfe8a1, 32'ha81a664b, 32'hc24b8b70, 32'hc76c51a3,
        32'hd192e819, 32'hd6990624, 32'hf40e3585, 32'h106aa070,
        32'h19a4c116, 32'h1e376c08, 32'h2748774c, 32'h34b0bcb5,
        32'h391c0cb3, 32'h4ed8aa4a, 32'h5b9cca4f, 32'h682e6ff3,
        32'h748f82ee, 32'h78a5636f, 32'h84c87814, 32'h8cc70208,
        32'h90befffa, 32'ha4506ceb, 32'hbef9a3f7, 32'hc67178f2
    };

    function automatic word_t rotr(input word_t x, input int n);
        return (x >> n) | (x << (WORD_W - n));
    endfunction

    function automatic word_t sched_s0(input word_t x);
        return rotr(x, 7) ^ rotr(x, 18) ^ (x >> 3);
    endfunction

    function automatic word_t sched_s1(input word_t x);
        return rotr(x, 17) ^ rotr(x, 19) ^ (x >> 10);
    endfunction

    function automatic vars_t add_vars(input vars_t x, input vars_t y);
        vars_t s;
        s.a = x.a + y.a;
        s.b = x.b + y.b;
        s.c = x.c + y.c;
        s.d = x.d + y.d;
        s.e = x.e + y.e;
        s.f = x.f + y.f;
        s.g = x.g + y.g;
        s.h = x.h + y.h;
        return s;
    endfunction

endpackage

// File: rtl/sha256_ctrl.sv
module sha256_ctrl
    import sha256_pkg::*;
#(
    parameter int ROUNDS = 64,
    localparam int CNT_W = $clog2(ROUNDS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    output logic             load_o,
    output logic             step_o,
    output logic             last_o,
    output logic             ready_o,
    output logic [CNT_W-1:0] round_o
);

    localparam logic [CNT_W-1:0] LAST_RND = CNT_W'(ROUNDS - 1);

    phase_t           state_q, state_d;
    logic [CNT_W-1:0] rnd_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i)          state_d = ST_RUN;
            ST_RUN:  if (rnd_q == LAST_RND) state_d = ST_DONE;
            ST_DONE: if (!start_i)         state_d = ST_IDLE;
            default:                       state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            rnd_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE)
                rnd_q <= '0;
            else if (state_q == ST_RUN && rnd_q != LAST_RND)
                rnd_q <= rnd_q + 1'b1;
        end
    end

    always_comb begin
        load_o  = 1'b0;
        step_o  = 1'b0;
        last_o  = 1'b0;
        ready_o = 1'b0;
        unique case (state_q)
            ST_IDLE: load_o  = start_i;
            ST_RUN: begin
                step_o = 1'b1;
                last_o = (rnd_q == LAST_RND);
            end
            ST_DONE: ready_o = 1'b1;
            default: ;
        endcase
    end

    assign round_o = rnd_q;

    a_r3_load_enters_run: assert property (@(posedge clk) disable iff (rst)
        load_o |=> (state_q == ST_RUN && rnd_q == '0));

    a_r9_rounds_advance: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RUN && rnd_q != LAST_RND) |=>
            (state_q == ST_RUN && rnd_q == $past(rnd_q) + 1'b1));

    a_r5_done_holds: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_DONE && start_i) |=> (state_q == ST_DONE));

    a_r6_release_to_idle: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_DONE && !start_i) |=> (state_q == ST_IDLE));

endmodule

// File: rtl/sha256_sched.sv
module sha256_sched
    import sha256_pkg::*;
#(
    parameter int NWORDS = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     load_i,
    input  logic                     step_i,
    input  logic [NWORDS*WORD_W-1:0] blk_i,
    output word_t                    w_o
);

    word_t win [NWORDS];
    word_t w_next;

    assign w_next = sched_s1(win[NWORDS-2]) + win[NWORDS-7]
                  + sched_s0(win[1]) + win[0];

    always_ff @(posedge clk) begin
        if (load_i) begin
            for (int i = 0; i < NWORDS; i++)
                win[i] <= blk_i[WORD_W*(NWORDS-1-i) +: WORD_W];
        end else if (step_i) begin
            for (int i = 0; i < NWORDS-1; i++)
                win[i] <= win[i+1];
            win[NWORDS-1] <= w_next;
        end
    end

    assign w_o = win[0];

    a_r2_first_word_is_top: assert property (@(posedge clk) disable iff (rst)
        load_i |=> (w_o == $past(blk_i[NWORDS*WORD_W-1 -: WORD_W])));

endmodule

// File: rtl/sha256_round.sv
module sha256_round
    import sha256_pkg::*;
(
    input  vars_t v_i,
    input  word_t k_i,
    input  word_t w_i,
    output vars_t v_o
);

    word_t big_s0, big_s1, choose, major, t1, t2;

    always_comb begin
        big_s1 = rotr(v_i.e, 6) ^ rotr(v_i.e, 11) ^ rotr(v_i.e, 25);
        big_s0 = rotr(v_i.a, 2) ^ rotr(v_i.a, 13) ^ rotr(v_i.a, 22);
        choose = (v_i.e & v_i.f) ^ (~v_i.e & v_i.g);
        major  = (v_i.a & v_i.b) ^ (v_i.a & v_i.c) ^ (v_i.b & v_i.c);
        t1     = v_i.h + big_s1 + choose + k_i + w_i;
        t2     = big_s0 + major;
        v_o.a  = t1 + t2;
        v_o.b  = v_i.a;
        v_o.c  = v_i.b;
        v_o.d  = v_i.c;
        v_o.e  = v_i.d + t1;
        v_o.f  = v_i.e;
        v_o.g  = v_i.f;
        v_o.h  = v_i.g;
    end

endmodule

// File: rtl/sha256_iter_core.sv
module sha256_iter_core
    import sha256_pkg::*;
#(
    parameter int NWORDS = 16,
    parameter int ROUNDS = 64,
    localparam int BLK_W = NWORDS * WORD_W,
    localparam int DIG_W = 8 * WORD_W,
    localparam int CNT_W = $clog2(ROUNDS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [BLK_W-1:0] blk_i,
    output logic [31:0]      a_o,
    output logic [31:0]      b_o,
    output logic [31:0]      c_o,
    output logic [31:0]      d_o,
    output logic [31:0]      e_o,
    output logic [31:0]      f_o,
    output logic [31:0]      g_o,
    output logic [31:0]      h_o,
    output logic             ready_o,
    output logic [DIG_W-1:0] digest_o
);

    logic             load, step, last;
    logic [CNT_W-1:0] rnd;
    word_t            w_cur;
    vars_t            work_q, chain_q, work_nxt;

    sha256_ctrl #(.ROUNDS(ROUNDS)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .start_i (start_i),
        .load_o  (load),
        .step_o  (step),
        .last_o  (last),
        .ready_o (ready_o),
        .round_o (rnd)
    );

    sha256_sched #(.NWORDS(NWORDS)) u_sched (
        .clk    (clk),
        .rst    (rst),
        .load_i (load),
        .step_i (step),
        .blk_i  (blk_i),
        .w_o    (w_cur)
    );

    sha256_round u_round (
        .v_i (work_q),
        .k_i (K_TAB[rnd]),
        .w_i (w_cur),
        .v_o (work_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            work_q  <= IV;
            chain_q <= IV;
        end else if (load) begin
            work_q <= chain_q;
        end else if (step) begin
            work_q <= work_nxt;
            if (last)
                chain_q <= add_vars(chain_q, work_nxt);
        end
    end

    assign a_o      = work_q.a;
    assign b_o      = work_q.b;
    assign c_o      = work_q.c;
    assign d_o      = work_q.d;
    assign e_o      = work_q.e;
    assign f_o      = work_q.f;
    assign g_o      = work_q.g;
    assign h_o      = work_q.h;
    assign digest_o = chain_q;

    a_r4_digest_moves_with_ready: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$stable(digest_o)) |-> $rose(ready_o));

    a_r5_hold_while_start: assert property (@(posedge clk) disable iff (rst)
        (ready_o && start_i) |=> (ready_o && $stable(digest_o)));

    a_r6_release_keeps_digest: assert property (@(posedge clk) disable iff (rst)
        (ready_o && !start_i) |=> (!ready_o && $stable(digest_o)));

endmodule

// File: tb/sha256_iter_core_test.sv
module sha256_iter_core_test;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [511:0] blk = '0;
    logic [31:0]  a_o, b_o, c_o, d_o, e_o, f_o, g_o, h_o;
    logic         ready;
    logic [255:0] digest;

    int           n_checks = 0;
    int           n_fail = 0;
    logic [31:0]  kb [64];
    logic [255:0] mchain;
    logic [255:0] last_dig;
    bit           finished = 1'b0;

    localparam logic [255:0] IV_B =
        256'h6a09e667bb67ae853c6ef372a54ff53a510e527f9b05688c1f83d9ab5be0cd19;

    always #2 clk = ~clk;

    sha256_iter_core uut (
        .clk(clk), .rst(rst), .start_i(start), .blk_i(blk),
        .a_o(a_o), .b_o(b_o), .c_o(c_o), .d_o(d_o),
        .e_o(e_o), .f_o(f_o), .g_o(g_o), .h_o(h_o),
        .ready_o(ready), .digest_o(digest)
    );

    function automatic logic [31:0] rr(input logic [31:0] x, input int n);
        return (x >> n) | (x << (32 - n));
    endfunction

    // returns {working variables after round 63, new chaining value}
    function automatic logic [511:0] model(input logic [255:0] ch, input logic [511:0] b);
        logic [31:0] w [64];
        logic [31:0] v [8];
        logic [31:0] t1, t2;
        logic [255:0] wk, nc;
        for (int t = 0; t < 16; t++) w[t] = b[32*(15-t) +: 32];
        for (int t = 16; t < 64; t++)
            w[t] = (rr(w[t-2], 17) ^ rr(w[t-2], 19) ^ (w[t-2] >> 10)) + w[t-7]
                 + (rr(w[t-15], 7) ^ rr(w[t-15], 18) ^ (w[t-15] >> 3)) + w[t-16];
        for (int i = 0; i < 8; i++) v[i] = ch[255-32*i -: 32];
        for (int t = 0; t < 64; t++) begin
            t1 = v[7] + (rr(v[4], 6) ^ rr(v[4], 11) ^ rr(v[4], 25))
               + ((v[4] & v[5]) ^ (~v[4] & v[6])) + kb[t] + w[t];
            t2 = (rr(v[0], 2) ^ rr(v[0], 13) ^ rr(v[0], 22))
               + ((v[0] & v[1]) ^ (v[0] & v[2]) ^ (v[1] & v[2]));
            v[7] = v[6]; v[6] = v[5]; v[5] = v[4]; v[4] = v[3] + t1;
            v[3] = v[2]; v[2] = v[1]; v[1] = v[0]; v[0] = t1 + t2;
        end
        for (int i = 0; i < 8; i++) begin
            wk[255-32*i -: 32] = v[i];
            nc[255-32*i -: 32] = v[i] + ch[255-32*i -: 32];
        end
        return {wk, nc};
    endfunction

    task automatic chk(input string req, input logic [255:0] act, input logic [255:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        start = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        mchain = IV_B;
    endtask

    // launch a block, check the ready timing (R3), digest (R4) and working vars (R8)
    task automatic do_block(input logic [511:0] b, input string tag);
        logic [511:0] r;
        @(negedge clk);
        blk = b;
        start = 1'b1;
        repeat (64) @(posedge clk);
        @(negedge clk);
        chk({"R3 not yet ready ", tag}, {255'b0, ready}, 256'd0);
        @(posedge clk);
        @(negedge clk);
        chk({"R3 ready ", tag}, {255'b0, ready}, 256'd1);
        r = model(mchain, b);
        chk({"R4 digest ", tag}, digest, r[255:0]);
        chk({"R8 working vars ", tag}, {a_o, b_o, c_o, d_o, e_o, f_o, g_o, h_o}, r[511:256]);
        mchain = r[255:0];
        last_dig = digest;
    endtask

    task automatic release_start(input string tag);
        start = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk({"R6 ready clears ", tag}, {255'b0, ready}, 256'd0);
        chk({"R6 digest kept ", tag}, digest, last_dig);
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog R3 actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [511:0] b1, b2, babc, rb;
        int np, cand;
        int unused_seed;
        real c;
        bit prime;

        np = 0;
        cand = 2;
        while (np < 64) begin
            prime = 1'b1;
            for (int d = 2; d * d <= cand; d++) if (cand % d == 0) prime = 1'b0;
            if (prime) begin
                c = $pow(real'(cand), 1.0 / 3.0);
                c = c - (c * c * c - real'(cand)) / (3.0 * c * c);
                kb[np] = 32'(longint'($floor((c - $floor(c)) * 4294967296.0)));
                np++;
            end
            cand++;
        end
        unused_seed = $urandom(32'h5eed1234);

        babc = '0;
        babc[511:480] = 32'h61626380;
        babc[31:0]    = 32'h00000018;
        b1 = '0;
        for (int i = 0; i < 14; i++)
            b1[32*(15-i) +: 32] = {8'h61 + 8'(i), 8'h62 + 8'(i), 8'h63 + 8'(i), 8'h64 + 8'(i)};
        b1[63:32] = 32'h80000000;
        b2 = '0;
        b2[31:0] = 32'h000001c0;

        // R1: reset state
        do_reset();
        chk("R1 digest after reset", digest, IV_B);
        chk("R1 ready after reset", {255'b0, ready}, 256'd0);
        chk("R1 working vars after reset", {a_o, b_o, c_o, d_o, e_o, f_o, g_o, h_o}, IV_B);

        // R2/R4: one-block vector, word 15 carries W0
        do_block(babc, "abc");
        chk("R2 R4 abc vector", digest,
            256'hba7816bf8f01cfea414140de5dae2223b00361a396177a9cb410ff61f20015ad);

        // R5: start held high keeps result and starts nothing
        repeat (70) @(posedge clk);
        @(negedge clk);
        chk("R5 ready held", {255'b0, ready}, 256'd1);
        chk("R5 digest held", digest, last_dig);
        release_start("abc");

        // R4/R6: two-block vector with chaining
        do_reset();
        do_block(b1, "two-block part 1");
        chk("R4 two-block intermediate", digest,
            256'h85e655d6417a17953363376a624cde5c76e09589cac5f811cc4b32c1f20e533a);
        release_start("part 1");
        do_block(b2, "two-block part 2");
        chk("R6 two-block chained final", digest,
            256'h248d6a61d20638b8e5c026930c3e6039a33ce45964ff2167f6ecedd419db06c1);
        release_start("part 2");

        // R9: start and block change during the run
        do_reset();
        @(negedge clk);
        blk = babc;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int j = 0; j < 16; j++) blk[32*j +: 32] = $urandom;
        repeat (63) @(posedge clk);
        @(negedge clk);
        chk("R9 not yet ready", {255'b0, ready}, 256'd0);
        @(posedge clk);
        @(negedge clk);
        chk("R9 ready despite start drop", {255'b0, ready}, 256'd1);
        chk("R9 digest unaffected", digest,
            256'hba7816bf8f01cfea414140de5dae2223b00361a396177a9cb410ff61f20015ad);
        @(posedge clk);
        @(negedge clk);
        chk("R9 ready clears after run", {255'b0, ready}, 256'd0);

        // R7: reset in the middle of a compression
        @(negedge clk);
        for (int j = 0; j < 16; j++) blk[32*j +: 32] = $urandom;
        start = 1'b1;
        repeat (20) @(posedge clk);
        do_reset();
        chk("R7 digest restored", digest, IV_B);
        chk("R7 ready low", {255'b0, ready}, 256'd0);
        repeat (70) @(posedge clk);
        @(negedge clk);
        chk("R7 no completion after abort", {255'b0, ready}, 256'd0);

        // random blocks, chained, with occasional resets
        for (int i = 0; i < 12; i++) begin
            if ($urandom % 4 == 0) do_reset();
            for (int j = 0; j < 16; j++) rb[32*j +: 32] = $urandom;
            if (i == 5) rb = '1;
            if (i == 6) rb = '0;
            do_block(rb, $sformatf("random %0d", i));
            if (i % 2 == 1) begin
                repeat (3 + ($urandom % 5)) @(posedge clk);
                @(negedge clk);
                chk("R5 random hold", digest, last_dig);
            end
            release_start($sformatf("random %0d", i));
            repeat ($urandom % 3) @(negedge clk);
        end

        finished = 1'b1;
        summary();
        $finish;
    end

endmodule